// File: doc/BRIEF.md
# Multiplexed LCD Drive Level Sequencer

This block drives a small multiplexed passive LCD with 4 common and 20 segment pins. Each pin's output is a 2-bit symbolic level code (VSS, VLC1, VLC2, VLC3). An external analog stage turns each code into a voltage. A display RAM holds one nibble per segment, with one bit for each common. A set bit lights the pixel where that common crosses that segment. Two 4-bit control registers set the following:

- the duty (2, 3 or 4 scanned commons);
- the bias (1/2 or 1/3);
- display enable;
- the internal bias divider;
- for each of the three lowest segment pins, whether it is a segment output or a bias supply pin.

A clock-enable input, `slot_tick`, sets the scan rate. Each pulse advances one half-slot. Every common slot has a first half with positive polarity and a second half with inverted polarity, so every pixel sees zero average DC. The scan counter restarts from the first half of COM0 whenever the duty or bias field changes. It also restarts whenever the display leaves the blank state.

The blank state applies after reset, while display drive is off, and while `backup` is high. In this state every common and segment output sits at VLC3, so no pixel sees a voltage.

Top module: `lcd_mux_seq`

## Requirements
- R1: After reset the display-control register is 0000 (drive off), the pin-function register is 1111, every common and segment code is VLC3 (2'b11), and `divider_on` is 0. Level codes: VSS=2'b00, VLC1=2'b01, VLC2=2'b10, VLC3=2'b11. COMi is `com_lvl[2i+1:2i]` and SEGj is `seg_lvl[2j+1:2j]`.
- R2: A write with `reg_sel`=0 loads the display-control register: bits [1:0] select the duty (00 = 2 commons, 01 = 3, 10 or 11 = 4), bit 2 selects the bias (0 = 1/2, 1 = 1/3), and bit 3 enables drive. A write with `reg_sel`=1 loads the pin-function register.
- R3: While active, each `slot_tick` advances one half-slot. The order is COM0 first half, COM0 second half, COM1 first half, and so on up to COM(N-1) second half, after which the scan wraps to COM0. N is the scanned common count.
- R4: The selected common is VLC3 in the first half and VSS in the second half.
- R5: A non-selected common, including any common at index N or above, is VLC1 in the first half and VLC2 in the second half at 1/3 bias. At 1/2 bias it is VLC1 in both halves.
- R6: A segment whose RAM bit for the selected common is 1 is VSS in the first half and VLC3 in the second half. This gives the full VLC3 swing across the lit pixel.
- R7: A segment whose bit is 0 is VLC2 in the first half and VLC1 in the second half at 1/3 bias. At 1/2 bias it is VLC1 in both halves.
- R8: While drive is disabled or `backup` is 1, every common and every segment-mode pin is VLC3 and the scan is held. On leaving this state the scan starts at COM0 first half.
- R9: Pin-function bits 0, 1 and 2 equal to 0 put SEG0, SEG1 and SEG2 in supply mode. These pins then output the constant codes VLC3, VLC2 and VLC1 respectively, and carry no segment waveform, even when blank.
- R10: A display-control write that changes bits [2:0] restarts the scan at COM0 first half. A write that leaves bits [2:0] unchanged does not disturb the scan.
- R11: `divider_on` is the inverse of pin-function bit 3.
- R12: A RAM write at an address of 20 or above has no effect. An in-range write replaces that segment's nibble, in which bit i belongs to COMi.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_tick | input | 1 | Half-slot advance enable |
| backup | input | 1 | RAM backup mode, forces blank |
| reg_wr | input | 1 | Control register write strobe |
| reg_sel | input | 1 | 0 = display control, 1 = pin function |
| reg_wdata | input | 4 | Register write data |
| ram_wr | input | 1 | Display RAM write strobe |
| ram_addr | input | 5 | Segment index to write |
| ram_wdata | input | 4 | Nibble, bit i for COMi |
| com_lvl | output | 8 | Common level codes, 2 bits per pin |
| seg_lvl | output | 40 | Segment level codes, 2 bits per pin |
| divider_on | output | 1 | Internal bias divider enable |

## Verification
Faults in the scan counter show up on the very next tick. They appear as the level pair on the commons: the wrong common at VLC3/VSS, no common selected, or two selected. The same fault changes which RAM column drives the segments. A stale duty or bias state shows within one half-slot, as middle levels that do not fold correctly or as commons beyond N being scanned. A missed restart leaves the first check after a duty change reading a common other than COM0. Blank, supply-pin and RAM-write faults appear on the pin codes in the same cycle as the register or input change.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

   typedef enum logic [1:0] {
      LV_VSS  = 2'd0,
      LV_VLC1 = 2'd1,
      LV_VLC2 = 2'd2,
      LV_VLC3 = 2'd3
   } lcd_lvl_e;

   localparam int SUPPLY_PINS = 3;

   // at half bias both middle levels become the single middle level
   function automatic lcd_lvl_e mid_fold(input lcd_lvl_e c, input logic bias3);
      return (!bias3 && c == LV_VLC2) ? LV_VLC1 : c;
   endfunction

   function automatic lcd_lvl_e com_code(input logic sel, input logic half,
                                         input logic bias3);
      if (sel) return half ? LV_VSS : LV_VLC3;
      return mid_fold(half ? LV_VLC2 : LV_VLC1, bias3);
   endfunction

   function automatic lcd_lvl_e seg_code(input logic on, input logic half,
                                         input logic bias3);
      if (on) return half ? LV_VLC3 : LV_VSS;
      return mid_fold(half ? LV_VLC1 : LV_VLC2, bias3);
   endfunction

   function automatic lcd_lvl_e supply_code(input int idx);
      case (idx)
         0:       return LV_VLC3;
         1:       return LV_VLC2;
         default: return LV_VLC1;
      endcase
   endfunction

endpackage

// File: rtl/lcd_ctrl_regs.sv
module lcd_ctrl_regs
   import lcd_seq_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic                   reg_sel,
   input  logic [3:0]             reg_wdata,
   output logic                   drive_en,
   output logic                   bias3,
   output logic [1:0]             duty_code,
   output logic [SUPPLY_PINS-1:0] pin_seg,
   output logic                   divider_on,
   output logic                   restart
);

   logic [3:0] dctl_q;
   logic [3:0] pfn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dctl_q <= 4'b0000;
         pfn_q  <= 4'b1111;
      end else if (reg_wr) begin
         if (reg_sel) pfn_q  <= reg_wdata;
         else         dctl_q <= reg_wdata;
      end
   end

   assign restart    = reg_wr && !reg_sel && (reg_wdata[2:0] != dctl_q[2:0]);
   assign duty_code  = dctl_q[1:0];
   assign bias3      = dctl_q[2];
   assign drive_en   = dctl_q[3];
   assign pin_seg    = pfn_q[SUPPLY_PINS-1:0];
   assign divider_on = !pfn_q[3];

   // R11
   divider_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel) |=> (divider_on == !$past(reg_wdata[3])));

   // R2
   dctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_sel) |=> ({drive_en, bias3, duty_code} == $past(reg_wdata)));

endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
   parameter int NUM_COM = 4,
   localparam int SLOT_W = (NUM_COM > 2) ? $clog2(NUM_COM) : 1,
   localparam int CNT_W  = SLOT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              hold,
   input  logic              restart,
   input  logic [1:0]        duty_code,
   output logic [SLOT_W-1:0] slot,
   output logic              half,
   output logic [CNT_W-1:0]  n_com
);

   logic [SLOT_W-1:0] slot_q;
   logic              half_q;

   always_comb begin
      int raw;
      case (duty_code)
         2'b00:   raw = 2;
         2'b01:   raw = 3;
         default: raw = 4;
      endcase
      n_com = CNT_W'((raw < NUM_COM) ? raw : NUM_COM);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         half_q <= 1'b0;
      end else if (hold || restart) begin
         slot_q <= '0;
         half_q <= 1'b0;
      end else if (tick) begin
         if (!half_q) begin
            half_q <= 1'b1;
         end else begin
            half_q <= 1'b0;
            if (({1'b0, slot_q} + 1'b1) >= n_com) slot_q <= '0;
            else                                  slot_q <= slot_q + 1'b1;
         end
      end
   end

   assign slot = slot_q;
   assign half = half_q;

   // R3
   slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, slot_q} < n_com);

   // R10
   restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (slot_q == '0 && !half_q));

   // R3
   half_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !hold && !restart && !half_q) |=> (half_q && $stable(slot_q)));

endmodule

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
   parameter int NUM_COM = 4,
   parameter int NUM_SEG = 20,
   localparam int SEG_AW = $clog2(NUM_SEG)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr,
   input  logic [SEG_AW-1:0]          addr,
   input  logic [NUM_COM-1:0]         wdata,
   output logic [NUM_SEG*NUM_COM-1:0] bits_flat
);

   logic [NUM_COM-1:0] mem_q [NUM_SEG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SEG; s++) mem_q[s] <= '0;
      end else if (wr && (int'(addr) < NUM_SEG)) begin
         mem_q[addr] <= wdata;
      end
   end

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_flat
      assign bits_flat[s*NUM_COM +: NUM_COM] = mem_q[s];
   end

endmodule

// File: rtl/lcd_level_gen.sv
module lcd_level_gen
   import lcd_seq_pkg::*;
#(
   parameter int NUM_COM = 4,
   parameter int NUM_SEG = 20,
   localparam int SLOT_W = (NUM_COM > 2) ? $clog2(NUM_COM) : 1,
   localparam int CNT_W  = SLOT_W + 1
) (
   input  logic                       active,
   input  logic                       bias3,
   input  logic                       half,
   input  logic [SLOT_W-1:0]          slot,
   input  logic [CNT_W-1:0]           n_com,
   input  logic [SUPPLY_PINS-1:0]     pin_seg,
   input  logic [NUM_SEG*NUM_COM-1:0] bits_flat,
   output logic [2*NUM_COM-1:0]       com_lvl,
   output logic [2*NUM_SEG-1:0]       seg_lvl
);

   for (genvar i = 0; i < NUM_COM; i++) begin : g_com
      localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
      logic sel;
      assign sel = (IDX < n_com) && (slot == IDX[SLOT_W-1:0]);
      assign com_lvl[2*i +: 2] = active ? com_code(sel, half, bias3) : LV_VLC3;
   end

   for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
      logic [1:0] wave;
      assign wave = active ? seg_code(bits_flat[j*NUM_COM + int'(slot)], half, bias3)
                           : LV_VLC3;
      if (j < SUPPLY_PINS) begin : g_dual
         assign seg_lvl[2*j +: 2] = pin_seg[j] ? wave : supply_code(j);
      end else begin : g_plain
         assign seg_lvl[2*j +: 2] = wave;
      end
   end

endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
   import lcd_seq_pkg::*;
#(
   parameter int NUM_COM = 4,
   parameter int NUM_SEG = 20,
   localparam int SEG_AW = $clog2(NUM_SEG),
   localparam int SLOT_W = (NUM_COM > 2) ? $clog2(NUM_COM) : 1,
   localparam int CNT_W  = SLOT_W + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 slot_tick,
   input  logic                 backup,
   input  logic                 reg_wr,
   input  logic                 reg_sel,
   input  logic [3:0]           reg_wdata,
   input  logic                 ram_wr,
   input  logic [SEG_AW-1:0]    ram_addr,
   input  logic [NUM_COM-1:0]   ram_wdata,
   output logic [2*NUM_COM-1:0] com_lvl,
   output logic [2*NUM_SEG-1:0] seg_lvl,
   output logic                 divider_on
);

   if (NUM_COM < 2 || NUM_COM > 4) begin : g_bad_com
      $error("NUM_COM must lie in 2..4");
   end
   if (NUM_SEG < SUPPLY_PINS) begin : g_bad_seg
      $error("NUM_SEG must cover the supply-capable pins");
   end

   logic                       drive_en, bias3, restart, active, half;
   logic [1:0]                 duty_code;
   logic [SUPPLY_PINS-1:0]     pin_seg;
   logic [SLOT_W-1:0]          slot;
   logic [CNT_W-1:0]           n_com;
   logic [NUM_SEG*NUM_COM-1:0] bits_flat;

   assign active = drive_en && !backup;

   lcd_ctrl_regs regs_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .drive_en(drive_en), .bias3(bias3),
      .duty_code(duty_code), .pin_seg(pin_seg), .divider_on(divider_on),
      .restart(restart)
   );

   lcd_scan_timer #(.NUM_COM(NUM_COM)) timer_i (
      .clk(clk), .rst_n(rst_n), .tick(slot_tick), .hold(!active),
      .restart(restart), .duty_code(duty_code), .slot(slot), .half(half),
      .n_com(n_com)
   );

   lcd_disp_ram #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) ram_i (
      .clk(clk), .rst_n(rst_n), .wr(ram_wr), .addr(ram_addr),
      .wdata(ram_wdata), .bits_flat(bits_flat)
   );

   lcd_level_gen #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) lvl_i (
      .active(active), .bias3(bias3), .half(half), .slot(slot),
      .n_com(n_com), .pin_seg(pin_seg), .bits_flat(bits_flat),
      .com_lvl(com_lvl), .seg_lvl(seg_lvl)
   );

   logic [NUM_COM-1:0] com_at_rail;
   for (genvar i = 0; i < NUM_COM; i++) begin : g_rail
      assign com_at_rail[i] = (com_lvl[2*i +: 2] == LV_VLC3) ||
                              (com_lvl[2*i +: 2] == LV_VSS);
   end

   // R4
   one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> ($countones(com_at_rail) == 1));

   // R8
   blank_com_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (com_lvl == {NUM_COM{LV_VLC3}}));

   for (genvar k = 0; k < SUPPLY_PINS; k++) begin : g_sup_chk
      // R9
      supply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!pin_seg[k] && $past(!pin_seg[k])) |-> $stable(seg_lvl[2*k +: 2]));
   end

endmodule

// File: tb/lcd_mux_seq_tb_top.sv
module lcd_mux_seq_tb_top;

   localparam int NC = 4;
   localparam int NS = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slot_tick = 1'b0, backup = 1'b0;
   logic          reg_wr = 1'b0, reg_sel = 1'b0;
   logic [3:0]    reg_wdata = '0;
   logic          ram_wr = 1'b0;
   logic [4:0]    ram_addr = '0;
   logic [NC-1:0] ram_wdata = '0;
   logic [2*NC-1:0] com_lvl;
   logic [2*NS-1:0] seg_lvl;
   logic          divider_on;

   always #5 clk = ~clk;

   lcd_mux_seq dut_i (
      .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .backup(backup),
      .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .ram_wr(ram_wr), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .com_lvl(com_lvl), .seg_lvl(seg_lvl), .divider_on(divider_on)
   );

   int n_chk = 0, n_err = 0;

   // behavioural model built from the requirements
   logic [3:0]    m_dctl = 4'b0000, m_pfn = 4'b1111;
   logic [NC-1:0] m_ram [NS];
   int            m_slot = 0, m_half = 0;
   logic          m_bk = 1'b0;

   function automatic int m_n();
      case (m_dctl[1:0])
         2'b00: return 2;
         2'b01: return 3;
         default: return 4;
      endcase
   endfunction

   function automatic logic m_act();
      return m_dctl[3] && !m_bk;
   endfunction

   function automatic logic [1:0] fold(input logic [1:0] c);
      return (!m_dctl[2] && c == 2'd2) ? 2'd1 : c;
   endfunction

   function automatic logic [1:0] e_com(input int i);
      if (!m_act()) return 2'd3;
      if (i < m_n() && i == m_slot) return (m_half != 0) ? 2'd0 : 2'd3;
      return fold((m_half != 0) ? 2'd2 : 2'd1);
   endfunction

   function automatic logic [1:0] e_seg(input int j);
      if (j < 3 && !m_pfn[j]) return 2'(3 - j);
      if (!m_act()) return 2'd3;
      if (m_ram[j][m_slot]) return (m_half != 0) ? 2'd3 : 2'd0;
      return fold((m_half != 0) ? 2'd1 : 2'd2);
   endfunction

   task automatic m_settle();
      if (!m_act()) begin m_slot = 0; m_half = 0; end
   endtask

   task automatic check_all(input string tag);
      logic [2*NC-1:0] ec;
      logic [2*NS-1:0] es;
      for (int i = 0; i < NC; i++) ec[2*i +: 2] = e_com(i);
      for (int j = 0; j < NS; j++) es[2*j +: 2] = e_seg(j);
      n_chk++;
      if (com_lvl !== ec || seg_lvl !== es) begin
         n_err++;
         $display("FAIL %s com=%h exp=%h seg=%h exp=%h", tag, com_lvl, ec, seg_lvl, es);
      end
   endtask

   task automatic check_bit(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic op_reg(input logic sel, input logic [3:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
      if (sel) m_pfn = d;
      else begin
         if (d[2:0] != m_dctl[2:0]) begin m_slot = 0; m_half = 0; end
         m_dctl = d;
      end
      m_settle();
   endtask

   task automatic op_tick();
      @(negedge clk); slot_tick = 1'b1;
      @(negedge clk); slot_tick = 1'b0;
      if (m_act()) begin
         if (m_half == 0) m_half = 1;
         else begin
            m_half = 0;
            m_slot = (m_slot + 1 >= m_n()) ? 0 : m_slot + 1;
         end
      end
      m_settle();
   endtask

   task automatic op_ram(input int a, input logic [NC-1:0] d);
      @(negedge clk); ram_wr = 1'b1; ram_addr = 5'(a); ram_wdata = d;
      @(negedge clk); ram_wr = 1'b0;
      if (a < NS) m_ram[a] = d;
   endtask

   task automatic op_backup(input logic v);
      @(negedge clk); backup = v;
      @(negedge clk);
      m_bk = v;
      m_settle();
   endtask

   task automatic t_reset();
      check_all("R1 reset levels");
      check_bit("R1 divider reset", divider_on, 1'b0);
      check_bit("R1 all commons VLC3", com_lvl == {NC{2'b11}}, 1'b1);
   endtask

   task automatic t_disabled();
      for (int j = 0; j < NS; j++) op_ram(j, 4'((j * 5 + 3) & 15));
      for (int k = 0; k < 3; k++) begin
         op_tick();
         check_all("R8 drive off blank");
      end
   endtask

   task automatic t_duty4_bias3();
      op_reg(1'b0, 4'b1110);
      check_all("R2 R4 first slot");
      for (int k = 0; k < 10; k++) begin
         op_tick();
         check_all("R3 R4 R5 R6 R7 duty4 bias3");
      end
   endtask

   task automatic t_duty3_bias3();
      op_reg(1'b0, 4'b1101);
      check_all("R10 restart to duty3");
      for (int k = 0; k < 8; k++) begin
         op_tick();
         check_all("R3 R5 duty3 bias3");
      end
   endtask

   task automatic t_duty2_bias2();
      op_reg(1'b0, 4'b1000);
      for (int k = 0; k < 6; k++) begin
         op_tick();
         check_all("R3 R5 R7 duty2 bias2");
      end
   endtask

   task automatic t_restart();
      op_tick(); op_tick(); op_tick();
      op_reg(1'b0, 4'b1000);
      check_all("R10 same value keeps scan");
      op_reg(1'b0, 4'b1100);
      check_all("R10 bias change restarts");
      op_tick();
      check_all("R10 after restart");
   endtask

   task automatic t_backup();
      op_reg(1'b0, 4'b1110);
      op_tick(); op_tick(); op_tick();
      op_backup(1'b1);
      check_all("R8 backup blank");
      op_tick();
      check_all("R8 backup holds");
      op_backup(1'b0);
      check_all("R8 resume at COM0");
   endtask

   task automatic t_supply();
      op_reg(1'b1, 4'b0000);
      check_bit("R11 divider on", divider_on, 1'b1);
      for (int k = 0; k < 4; k++) begin
         op_tick();
         check_all("R9 supply pins fixed");
      end
      op_reg(1'b1, 4'b1010);
      check_all("R9 mixed pin function");
      op_reg(1'b0, 4'b0110);
      check_all("R9 supply during blank");
      op_reg(1'b1, 4'b1111);
      check_bit("R11 divider off", divider_on, 1'b0);
      op_reg(1'b0, 4'b1111);
   endtask

   task automatic t_ram_bounds();
      op_ram(20, 4'hF);
      op_ram(31, 4'hF);
      for (int k = 0; k < 3; k++) begin
         op_tick();
         check_all("R12 out of range ignored");
      end
      op_ram(19, 4'hF);
      op_ram(0, 4'h0);
      for (int k = 0; k < 4; k++) begin
         op_tick();
         check_all("R12 in range write");
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      for (int j = 0; j < NS; j++) m_ram[j] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_duty4_bias3();
      t_duty3_bias3();
      t_duty2_bias2();
      t_restart();
      t_backup();
      t_supply();
      t_ram_bounds();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule